// File: doc/BRIEF.md
# Cycle Count and Compare Timer with Cause Bits

The block is a timer that sits beside a processor core. A 32-bit counter advances by one on every cycle in which the tick-enable input is high. A second 32-bit register holds a compare value. When an increment makes the counter equal to the compare value, a sticky timer-pending bit is set in a cause word. That bit stays set until software writes the compare register again. The same cause word also carries a copy of one level-sensitive external interrupt request. The interrupt output is high while either of the two cause bits is set.

Software reaches the counter, the compare register and the cause word through a single-cycle write port and a registered read port. Both ports are addressed by a 2-bit selector. The two cause bits belong to the hardware, so software cannot write them. Because the counter starts at 1 and the compare register starts at 0, the first timer interrupt after reset comes only once the counter has wrapped.

Top module: `cnt_cmp_timer`

## Requirements
- R1: With `tick_en` high and no counter write, the counter increases by one at the clock edge, wrapping from 0xFFFFFFFF to 0. With `tick_en` low it holds its value.
- R2: When an increment makes the counter equal to the compare register, cause bit 15 (value 0x8000) is set at that edge. It stays set while no compare write occurs.
- R3: A write to the compare register (`wr_sel` = 1) clears cause bit 15 at that edge. If a match and a compare write fall in the same cycle, the bit ends up clear.
- R4: A counter write (`wr_sel` = 0) loads `wr_data` into the counter. It takes priority over a tick in the same cycle and leaves the compare register unchanged. Without a compare write, the compare register holds its value.
- R5: Loading the counter with a value equal to the compare register sets no pending bit. Only a later increment into the compare value does.
- R6: Cause bit 10 (value 0x400) holds the value `ext_irq` had at the previous clock edge. It rises and falls with that input.
- R7: `irq_out` equals cause bit 15 OR cause bit 10, and changes at the same edge as those bits.
- R8: `rd_sel` selects 0 = counter, 1 = compare, 2 = cause word, 3 = zero. At each edge `rd_data` registers the selected value as it was before that edge.
- R9: A synchronous active-high `rst` sets the counter to 1 and the compare register to 0. It also clears the cause word, `irq_out` and `rd_data`.
- R10: Writes with `wr_sel` = 2 (cause) or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| ext_irq | input | 1 | Level-sensitive external interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare, 2/3 none |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read source: 0 counter, 1 compare, 2 cause, 3 zero |
| rd_data | output | 32 | Registered read value |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can land in the same cycle. An increment can reach the compare value in exactly the cycle software rewrites the compare register. A counter write can also coincide with a tick. The bench sets up each case by loading the counter one or two steps below the compare value and then issuing the write together with the tick. It judges the result by reading back the cause word and the counter, which must show a clear pending bit and the loaded value. A cycle-accurate behavioural model also runs constrained random traffic that keeps the counter near the compare value, so these collisions recur many times. On every clock it compares `rd_data` and `irq_out` against the model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CAUSE   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = W'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] inc_val,
  output logic         inc_fire
);
  // the next value wraps naturally at W bits
  assign inc_val  = cnt_q + W'(1);
  // a load has priority over a tick
  assign inc_fire = tick & ~ld;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= RST_VAL;
    else if (ld)       cnt_q <= ld_val;
    else if (inc_fire) cnt_q <= inc_val;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 32,
  parameter logic [W-1:0] CMP_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic         inc_fire,
  input  logic [W-1:0] inc_val,
  output logic [W-1:0] cmp_q,
  output logic         pend_q,
  output logic         pend_nxt
);
  logic hit;

  // a match is taken only on an increment, never on a load
  assign hit = inc_fire && (inc_val == cmp_q);

  // a compare write wins over a match in the same cycle
  always_comb begin
    if (wr_cmp)   pend_nxt = 1'b0;
    else if (hit) pend_nxt = 1'b1;
    else          pend_nxt = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= CMP_RST;
      pend_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= wr_val;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/tmr_cause.sv
module tmr_cause #(
  parameter int W = 32,
  parameter int TIMER_BIT = 15,
  parameter int EXT_BIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_irq,
  input  logic         pend_q,
  input  logic         pend_nxt,
  output logic         ext_q,
  output logic [W-1:0] cause_w,
  output logic         irq_q
);
  always_comb begin
    cause_w            = '0;
    cause_w[TIMER_BIT] = pend_q;
    cause_w[EXT_BIT]   = ext_q;
  end

  // the output is registered from next-state values so it moves with the bits
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ext_q <= ext_irq;
      irq_q <= pend_nxt | ext_irq;
    end
  end
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer #(
  parameter int DATA_W = 32,
  parameter int TIMER_BIT = 15,
  parameter int EXT_BIT = 10,
  parameter logic [DATA_W-1:0] COUNT_INIT = DATA_W'(1),
  parameter logic [DATA_W-1:0] COMPARE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ext_irq,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  import tmr_pkg::*;

  reg_sel_e          wsel, rsel;
  logic              wr_cnt, wr_cmp;
  logic [DATA_W-1:0] cnt_q, inc_val, cmp_q, cause_w;
  logic              inc_fire, pend_q, pend_nxt, ext_q;

  assign wsel   = reg_sel_e'(wr_sel);
  assign rsel   = reg_sel_e'(rd_sel);
  assign wr_cnt = wr_en && (wsel == SEL_COUNT);
  assign wr_cmp = wr_en && (wsel == SEL_COMPARE);

  tmr_counter #(.W(DATA_W), .RST_VAL(COUNT_INIT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .ld(wr_cnt), .ld_val(wr_data),
    .cnt_q(cnt_q), .inc_val(inc_val), .inc_fire(inc_fire)
  );

  tmr_match #(.W(DATA_W), .CMP_RST(COMPARE_INIT)) u_match (
    .clk(clk), .rst(rst), .wr_cmp(wr_cmp), .wr_val(wr_data),
    .inc_fire(inc_fire), .inc_val(inc_val),
    .cmp_q(cmp_q), .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  tmr_cause #(.W(DATA_W), .TIMER_BIT(TIMER_BIT), .EXT_BIT(EXT_BIT)) u_cause (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .pend_q(pend_q),
    .pend_nxt(pend_nxt), .ext_q(ext_q), .cause_w(cause_w), .irq_q(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rsel)
        SEL_COUNT:   rd_data <= cnt_q;
        SEL_COMPARE: rd_data <= cmp_q;
        SEL_CAUSE:   rd_data <= cause_w;
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              ext_irq,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_out,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] cmp_q,
  input logic              pend_q,
  input logic              ext_q
);
  logic              ld_c, ld_p;
  logic [DATA_W-1:0] cnt_plus;
  assign ld_c     = wr_en && (wr_sel == 2'd0);
  assign ld_p     = wr_en && (wr_sel == 2'd1);
  assign cnt_plus = cnt_q + DATA_W'(1);

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    tick_en && !ld_c |=> cnt_q == $past(cnt_plus));
  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en && !ld_c |=> $stable(cnt_q));
  a_r4_count_load: assert property (@(posedge clk) disable iff (rst)
    ld_c |=> cnt_q == $past(wr_data));
  a_r4_compare_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_p |=> $stable(cmp_q));
  a_r2_match_sets: assert property (@(posedge clk) disable iff (rst)
    tick_en && !ld_c && !ld_p && (cnt_plus == cmp_q) |=> pend_q);
  a_r2_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    pend_q && !ld_p |=> pend_q);
  a_r3_compare_clears: assert property (@(posedge clk) disable iff (rst)
    ld_p |=> !pend_q);
  a_r5_load_no_set: assert property (@(posedge clk) disable iff (rst)
    !pend_q && ld_c |=> !pend_q);
  a_r6_ext_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ext_q == $past(ext_irq));
  a_r7_irq_combine: assert property (@(posedge clk) disable iff (rst)
    irq_out == (pend_q | ext_q));
endmodule

bind cnt_cmp_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .ext_irq(ext_irq), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .irq_out(irq_out), .cnt_q(cnt_q),
  .cmp_q(cmp_q), .pend_q(pend_q), .ext_q(ext_q)
);

// File: tb/cnt_cmp_timer_tb.sv
module cnt_cmp_timer_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        ext_irq = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_cmp_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_irq(ext_irq),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_cmp, e_rd, nxt;
  logic        m_pend, m_ext, e_irq, m_valid = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 1'b0; m_ext = 1'b0;
      e_rd = 32'd0; e_irq = 1'b0; m_valid = 1'b1;
    end else begin
      case (rd_sel)
        2'd0: e_rd = m_cnt;
        2'd1: e_rd = m_cmp;
        2'd2: e_rd = ({31'd0, m_pend} << 15) | ({31'd0, m_ext} << 10);
        default: e_rd = 32'd0;
      endcase
      nxt = m_cnt + 32'd1;
      if (wr_en && wr_sel == 2'd1) m_pend = 1'b0;
      else if (tick_en && !(wr_en && wr_sel == 2'd0) && nxt == m_cmp) m_pend = 1'b1;
      if (wr_en && wr_sel == 2'd0) m_cnt = wr_data;
      else if (tick_en) m_cnt = nxt;
      if (wr_en && wr_sel == 2'd1) m_cmp = wr_data;
      m_ext = ext_irq;
      e_irq = m_pend | m_ext;
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      n_chk++;
      if (rd_data !== e_rd) begin
        n_bad++;
        $display("FAIL R8 model rd_data sel=%0d actual=%h expected=%h", rd_sel, rd_data, e_rd);
      end
      n_chk++;
      if (irq_out !== e_irq) begin
        n_bad++;
        $display("FAIL R7 model irq_out actual=%b expected=%b", irq_out, e_irq);
      end
    end
  end

  task automatic step(input bit tk, input bit we, input logic [1:0] ws,
                      input logic [31:0] wd, input logic [1:0] rs);
    tick_en = tk; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R9 reset values
    step(0, 0, 0, 0, 2'd0); chk("R9 count after reset", rd_data, 32'd1);
    step(0, 0, 0, 0, 2'd1); chk("R9 compare after reset", rd_data, 32'd0);
    step(0, 0, 0, 0, 2'd2); chk("R9 cause after reset", rd_data, 32'd0);
    chk("R9 irq after reset", {31'd0, irq_out}, 32'd0);
    // R1 increment and hold
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 2'd3);
    step(0, 0, 0, 0, 2'd0); step(0, 0, 0, 0, 2'd0);
    chk("R1 count after five ticks and hold", rd_data, 32'd6);
    // R4 load beats tick, then R1 wrap into initial compare 0 sets R2
    step(1, 1, 2'd0, 32'hFFFF_FFFE, 2'd3);
    step(1, 0, 0, 0, 2'd3);
    step(1, 0, 0, 0, 2'd3);
    chk("R2 irq after wrap match", {31'd0, irq_out}, 32'd1);
    step(0, 0, 0, 0, 2'd2); chk("R2 cause after wrap match", rd_data, 32'h8000);
    step(0, 0, 0, 0, 2'd0); chk("R1 count wrapped", rd_data, 32'd0);
    step(0, 0, 0, 0, 2'd1); chk("R4 compare unchanged", rd_data, 32'd0);
    // R10 writes to cause and unused select
    step(0, 1, 2'd2, 32'h0, 2'd3);
    step(0, 1, 2'd3, 32'h1234, 2'd3);
    step(0, 0, 0, 0, 2'd2); chk("R10 cause unchanged", rd_data, 32'h8000);
    step(0, 0, 0, 0, 2'd0); chk("R10 count unchanged", rd_data, 32'd0);
    // R3 compare write clears
    step(0, 1, 2'd1, 32'd100, 2'd3);
    chk("R3 irq after compare write", {31'd0, irq_out}, 32'd0);
    step(0, 0, 0, 0, 2'd2); chk("R3 cause after compare write", rd_data, 32'd0);
    // R5 load equal to compare
    step(0, 1, 2'd0, 32'd100, 2'd3);
    step(1, 0, 0, 0, 2'd3); step(1, 0, 0, 0, 2'd3);
    step(0, 0, 0, 0, 2'd2); chk("R5 no pending after equal load", rd_data, 32'd0);
    // R3 same-cycle match and compare write
    step(0, 1, 2'd0, 32'd98, 2'd3);
    step(1, 0, 0, 0, 2'd3);
    step(1, 1, 2'd1, 32'd500, 2'd3);
    step(0, 0, 0, 0, 2'd2); chk("R3 write beats match", rd_data, 32'd0);
    step(0, 0, 0, 0, 2'd0); chk("R1 count reached old compare", rd_data, 32'd100);
    // R2 normal match and stickiness
    step(0, 1, 2'd0, 32'd498, 2'd3);
    step(1, 0, 0, 0, 2'd3); step(1, 0, 0, 0, 2'd3);
    step(1, 0, 0, 0, 2'd3); step(1, 0, 0, 0, 2'd3);
    step(0, 0, 0, 0, 2'd2); chk("R2 sticky pending", rd_data, 32'h8000);
    // R6 / R7 external level
    ext_irq = 1'b1;
    step(0, 0, 0, 0, 2'd3);
    step(0, 0, 0, 0, 2'd2); chk("R6 ext bit set", rd_data, 32'h8400);
    step(0, 1, 2'd1, 32'd0, 2'd3);
    chk("R7 irq held by ext", {31'd0, irq_out}, 32'd1);
    step(0, 0, 0, 0, 2'd2); chk("R6 ext bit alone", rd_data, 32'h0400);
    ext_irq = 1'b0;
    step(0, 0, 0, 0, 2'd3);
    chk("R7 irq low", {31'd0, irq_out}, 32'd0);
    step(0, 0, 0, 0, 2'd2); chk("R6 ext bit cleared", rd_data, 32'd0);
    // random traffic near the compare value
    begin
      logic [31:0] lf = 32'hACE1_2345;
      for (int i = 0; i < 6000; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[7:4] == 4'd3) ext_irq = ~ext_irq;
        if (lf[12:9] == 4'd0)
          step(lf[2:0] != 3'd0, 1'b1, 2'd0, m_cmp - {29'd0, lf[15:13]}, lf[17:16]);
        else if (lf[12:9] == 4'd1)
          step(lf[2:0] != 3'd0, 1'b1, 2'd1, m_cnt + {29'd0, lf[15:13]}, lf[17:16]);
        else if (lf[12:9] == 4'd2)
          step(lf[2:0] != 3'd0, 1'b1, lf[19:18] | 2'd2, lf, lf[17:16]);
        else
          step(lf[2:0] != 3'd0, 1'b0, 2'd0, 32'd0, lf[17:16]);
      end
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end
endmodule